// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ninth-Bit Address Filtering

This block receives asynchronous serial frames on a single line and holds the last accepted byte in a one-entry receive buffer. The line is read at sixteen oversampling ticks per bit, and each bit is taken in the middle of its period. A frame has a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and a high stop bit. A small register bus sets the control bits and reads back status and data. A level output signals that an unread byte is waiting.

In nine-bit mode the ninth bit can act as an address marker. With filtering on, only frames whose ninth bit is set reach the buffer, so a node on a shared line ignores data traffic until it is addressed. With filtering off, every frame is kept, and the ninth bit is passed through for software to use, for example as a parity bit. Two sticky flags report a stop bit sampled low (framing) and a frame lost to a full buffer (overrun). The overrun flag is cleared only by dropping the receive enable.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x00 and `rx_ready` is low.
- R2: While the port enable (control bit 0) is 0, activity on `rx_in` loads nothing and `rx_ready` stays low.
- R3: While the receive enable (control bit 1) is 0, no frame is received. The single-shot bit (control bit 4) can be written and read back, but it starts no reception.
- R4: With control bit 2 at 0, a frame of 8 data bits, least significant bit first, is loaded into the data register (address 1). The ninth-bit status (bit 5) then reads 0 and `rx_ready` goes high.
- R5: With control bit 2 at 1, a ninth bit follows the data bits, and its value appears as status bit 5 together with the byte.
- R6: With both control bit 2 and address filtering (control bit 3) at 1, a frame whose ninth bit is 0 is discarded and leaves `rx_ready` low. A frame whose ninth bit is 1 is loaded.
- R7: With control bit 2 at 1 and filtering off, frames are loaded whatever their ninth bit.
- R8: Status bit 6 (framing error) is set when a loaded frame's stop bit is sampled low. It is rewritten only when the next frame is loaded.
- R9: A frame that completes while the buffer is unread sets status bit 7 (overrun). While that flag is set, completed frames are dropped and the buffer keeps its byte.
- R10: The overrun flag stays set through any write that keeps control bit 1 at 1. It clears once control bit 1 is written 0.
- R11: A start bit that is high again at its midpoint (8 ticks after the falling edge) is rejected, and the receiver returns to waiting for a start bit.
- R12: A read of the data register clears `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| bus_wr | input | 1 | Write strobe for the control register |
| bus_rd | input | 1 | Read strobe; a read at address 1 pops the buffer |
| bus_addr | input | 1 | 0 selects control/status, 1 selects data |
| bus_wdata | input | 5 | Control bits: 0 port enable, 1 receive enable, 2 nine-bit, 3 filter, 4 single-shot |
| bus_rdata | output | 8 | Read data: at address 0, control in bits 4:0, ninth bit in 5, framing error in 6, overrun in 7 |
| rx_ready | output | 1 | Unread byte present (interrupt flag) |

## Verification
Eight-bit frames with different bit patterns confirm bit order and data placement. Nine-bit frames with the ninth bit set and clear are each sent with filtering on and with it off: the filter must drop only the clear case, and pass-through must keep both. A frame with a low stop bit followed by a clean one shows that the framing flag follows the byte being read. Back-to-back unread frames, then a third frame, then enable writes separate overrun detection, frame dropping and the clearing rule. A short low pulse, followed by a valid frame, shows that glitch rejection leaves the receiver able to take the next frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   localparam int DATA_W = 8;
   localparam int CTRL_W = 5;

   // control register bit positions
   localparam int C_PORT  = 0;
   localparam int C_RUN   = 1;
   localparam int C_NINE  = 2;
   localparam int C_FILT  = 3;
   localparam int C_SHOT  = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

   typedef struct packed {
      logic [DATA_W-1:0] data;
      logic              ninth;
      logic              stop_bad;
   } rx_frame_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rx_line_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], line_in};
   end

   assign line_out = chain_q[STAGES-1];

endmodule

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
   import uart_rx_pkg::*;
#(
   parameter int OSR          = 16,
   parameter bit NINE_SUPPORT = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      line_s,
   input  logic      tick,
   input  logic      enable,
   input  logic      nine_mode,
   output logic      frame_valid,
   output rx_frame_t frame
);

   localparam int CNT_W = $clog2(OSR);
   localparam int HALF  = OSR / 2;
   localparam int IDX_W = 4;
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(HALF - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OSR - 1);

   logic       nine_eff;
   logic [IDX_W-1:0] last_idx;

   generate
      if (NINE_SUPPORT) begin : g_nine
         assign nine_eff = nine_mode;
      end else begin : g_eight
         logic unused_nine;
         assign unused_nine = nine_mode;
         assign nine_eff    = 1'b0;
      end
   endgenerate

   assign last_idx = nine_eff ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

   rx_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] idx_q;
   logic [DATA_W:0]  bits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cnt_q       <= '0;
         idx_q       <= '0;
         bits_q      <= '0;
         frame_valid <= 1'b0;
         frame       <= '0;
      end else begin
         frame_valid <= 1'b0;
         if (!enable) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
         end else if (tick) begin
            case (state_q)
               ST_IDLE: begin
                  if (!line_s) begin
                     state_q <= ST_START;
                     cnt_q   <= '0;
                  end
               end
               ST_START: begin
                  if (cnt_q == CNT_MID) begin
                     cnt_q <= '0;
                     if (line_s) begin
                        state_q <= ST_IDLE;
                     end else begin
                        state_q <= ST_DATA;
                        idx_q   <= '0;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt_q == CNT_FULL) begin
                     cnt_q         <= '0;
                     bits_q[idx_q] <= line_s;
                     if (idx_q == last_idx) state_q <= ST_STOP;
                     else                   idx_q   <= idx_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt_q == CNT_FULL) begin
                     cnt_q          <= '0;
                     state_q        <= ST_IDLE;
                     frame_valid    <= 1'b1;
                     frame.data     <= bits_q[DATA_W-1:0];
                     frame.ninth    <= nine_eff & bits_q[DATA_W];
                     frame.stop_bad <= ~line_s;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/rx_hold_buffer.sv
module rx_hold_buffer
   import uart_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_valid,
   input  rx_frame_t         frame,
   input  logic              nine_mode,
   input  logic              filter_en,
   input  logic              run_en,
   input  logic              pop,
   output logic [DATA_W-1:0] buf_data,
   output logic              buf_ninth,
   output logic              frame_err,
   output logic              overrun,
   output logic              full,
   output logic              load
);

   logic accept;

   // address filter: in nine-bit mode with filtering on, only marked frames pass
   assign accept = frame_valid & ~(filter_en & nine_mode & ~frame.ninth);
   assign load   = accept & ~overrun & ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_data  <= '0;
         buf_ninth <= 1'b0;
         frame_err <= 1'b0;
         full      <= 1'b0;
      end else if (load) begin
         buf_data  <= frame.data;
         buf_ninth <= frame.ninth;
         frame_err <= frame.stop_bad;
         full      <= 1'b1;
      end else if (pop) begin
         full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             overrun <= 1'b0;
      else if (!run_en)                       overrun <= 1'b0;
      else if (accept && !overrun && full)    overrun <= 1'b1;
   end

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
   import uart_rx_pkg::*;
#(
   parameter int OSR          = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit NINE_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_in,
   input  logic              baud_tick,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_addr,
   input  logic [CTRL_W-1:0] bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              rx_ready
);

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("uart_addr_rx: OSR must be even and at least 4");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic              port_en, run_en, nine_q, filt_en, rx_en;
   logic              line_s;
   logic              frame_valid;
   rx_frame_t         frame;
   logic              pop;
   logic [DATA_W-1:0] buf_data;
   logic              buf_ninth, frame_err, overrun, full, load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_q <= '0;
      else if (bus_wr && !bus_addr) ctrl_q <= bus_wdata;
   end

   assign port_en = ctrl_q[C_PORT];
   assign run_en  = ctrl_q[C_RUN];
   assign nine_q  = ctrl_q[C_NINE];
   assign filt_en = ctrl_q[C_FILT];
   assign rx_en   = port_en & run_en;
   assign pop     = bus_rd & bus_addr;

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (rx_in),
      .line_out (line_s)
   );

   rx_frame_sampler #(.OSR(OSR), .NINE_SUPPORT(NINE_SUPPORT)) u_samp (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_s      (line_s),
      .tick        (baud_tick),
      .enable      (rx_en),
      .nine_mode   (nine_q),
      .frame_valid (frame_valid),
      .frame       (frame)
   );

   rx_hold_buffer u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_valid (frame_valid),
      .frame       (frame),
      .nine_mode   (nine_q),
      .filter_en   (filt_en),
      .run_en      (run_en),
      .pop         (pop),
      .buf_data    (buf_data),
      .buf_ninth   (buf_ninth),
      .frame_err   (frame_err),
      .overrun     (overrun),
      .full        (full),
      .load        (load)
   );

   always_comb begin
      if (bus_addr) bus_rdata = buf_data;
      else          bus_rdata = {overrun, frame_err, buf_ninth, ctrl_q};
   end

   assign rx_ready = full;

endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pop,
   input logic       load,
   input logic       rx_ready,
   input logic       overrun,
   input logic       run_en,
   input logic       rx_en,
   input logic       frame_valid,
   input logic       filt_en,
   input logic       nine_q,
   input logic       frame_ninth,
   input logic [7:0] buf_data
);

   a_r12_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !load) |=> !rx_ready);

   a_r4_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> rx_ready);

   a_r9_buffer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> $stable(buf_data));

   a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && run_en) |=> overrun);

   a_r2_off_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !frame_valid);

   a_r6_filtered_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && filt_en && nine_q && !frame_ninth) |-> !load);

endmodule

bind uart_addr_rx uart_addr_rx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pop         (pop),
   .load        (load),
   .rx_ready    (rx_ready),
   .overrun     (overrun),
   .run_en      (run_en),
   .rx_en       (rx_en),
   .frame_valid (frame_valid),
   .filt_en     (filt_en),
   .nine_q      (nine_q),
   .frame_ninth (frame.ninth),
   .buf_data    (buf_data)
);

// File: tb/sim_uart_addr_rx.sv
module sim_uart_addr_rx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_in = 1'b1;
   logic       baud_tick = 1'b1;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic       bus_addr = 1'b0;
   logic [4:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rx_ready;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   uart_addr_rx u0 (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_ready(rx_ready)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [4:0] v);
      @(negedge clk); bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = v;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic peek(input logic a, output logic [7:0] v);
      @(negedge clk); bus_addr = a; #1 v = bus_rdata;
   endtask

   task automatic pop(output logic [7:0] v);
      @(negedge clk); bus_addr = 1'b1; bus_rd = 1'b1; #1 v = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic send(input logic [8:0] v, input bit nine, input bit stop_ok);
      @(negedge clk); rx_in = 1'b0;
      repeat (15) @(negedge clk);
      for (int i = 0; i < (nine ? 9 : 8); i++) begin
         rx_in = v[i];
         repeat (16) @(negedge clk);
      end
      rx_in = stop_ok;
      repeat (16) @(negedge clk);
      rx_in = 1'b1;
      repeat (24) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      peek(1'b0, v);
      check("R1 ctrl/status", v, 8'h00);
      check("R1 ready", {7'd0, rx_ready}, 8'h00);
   endtask

   task automatic t_disabled();
      logic [7:0] v;
      wr_ctrl(5'h02);
      send(9'h0C3, 0, 1);
      check("R2 port off", {7'd0, rx_ready}, 8'h00);
      wr_ctrl(5'h11);
      send(9'h0C3, 0, 1);
      check("R3 run off ready", {7'd0, rx_ready}, 8'h00);
      peek(1'b0, v);
      check("R3 shot bit readback", v, 8'h11);
   endtask

   task automatic t_eight();
      logic [7:0] v;
      wr_ctrl(5'h03);
      send(9'h0A5, 0, 1);
      check("R4 ready", {7'd0, rx_ready}, 8'h01);
      peek(1'b0, v);
      check("R4 ninth clear", {7'd0, v[5]}, 8'h00);
      pop(v);
      check("R4 data A5", v, 8'hA5);
      check("R12 ready cleared", {7'd0, rx_ready}, 8'h00);
      send(9'h03C, 0, 1);
      pop(v);
      check("R4 data 3C", v, 8'h3C);
   endtask

   task automatic t_nine();
      logic [7:0] v;
      wr_ctrl(5'h07);
      send(9'h15A, 1, 1);
      peek(1'b0, v);
      check("R5 ninth set", {7'd0, v[5]}, 8'h01);
      pop(v);
      check("R5 data", v, 8'h5A);
      send(9'h0E1, 1, 1);
      check("R7 unmarked kept", {7'd0, rx_ready}, 8'h01);
      peek(1'b0, v);
      check("R7 ninth clear", {7'd0, v[5]}, 8'h00);
      pop(v);
      check("R7 data", v, 8'hE1);
   endtask

   task automatic t_filter();
      logic [7:0] v;
      wr_ctrl(5'h0F);
      send(9'h077, 1, 1);
      check("R6 unmarked dropped", {7'd0, rx_ready}, 8'h00);
      send(9'h181, 1, 1);
      check("R6 marked ready", {7'd0, rx_ready}, 8'h01);
      pop(v);
      check("R6 marked data", v, 8'h81);
   endtask

   task automatic t_framing();
      logic [7:0] v;
      wr_ctrl(5'h03);
      send(9'h0B2, 0, 0);
      peek(1'b0, v);
      check("R8 ferr set", {7'd0, v[6]}, 8'h01);
      pop(v);
      check("R8 bad-stop data", v, 8'hB2);
      send(9'h04D, 0, 1);
      peek(1'b0, v);
      check("R8 ferr refreshed", {7'd0, v[6]}, 8'h00);
      pop(v);
   endtask

   task automatic t_overrun();
      logic [7:0] v;
      wr_ctrl(5'h03);
      send(9'h011, 0, 1);
      send(9'h022, 0, 1);
      peek(1'b0, v);
      check("R9 oerr set", {7'd0, v[7]}, 8'h01);
      pop(v);
      check("R9 first byte kept", v, 8'h11);
      send(9'h033, 0, 1);
      check("R9 dropped while oerr", {7'd0, rx_ready}, 8'h00);
      wr_ctrl(5'h03);
      peek(1'b0, v);
      check("R10 oerr sticky", {7'd0, v[7]}, 8'h01);
      wr_ctrl(5'h01);
      peek(1'b0, v);
      check("R10 oerr cleared", {7'd0, v[7]}, 8'h00);
      wr_ctrl(5'h03);
      send(9'h044, 0, 1);
      pop(v);
      check("R10 receives after clear", v, 8'h44);
   endtask

   task automatic t_glitch();
      logic [7:0] v;
      wr_ctrl(5'h03);
      @(negedge clk); rx_in = 1'b0;
      repeat (4) @(negedge clk);
      rx_in = 1'b1;
      repeat (40) @(negedge clk);
      check("R11 glitch rejected", {7'd0, rx_ready}, 8'h00);
      send(9'h096, 0, 1);
      pop(v);
      check("R11 frame after glitch", v, 8'h96);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_disabled();
      t_eight();
      t_nine();
      t_filter();
      t_framing();
      t_overrun();
      t_glitch();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule